// File: doc/BRIEF.md
# Gamma Table Template Loader

This block holds a 256-word, 10-bit gamma lookup-table template and fills it through a byte-wide register port. The host first sets a start index. It then sets the two upper data bits in their own register. Each write of the lower data byte stores the assembled 10-bit word at the current index and moves the index forward by one. A full table can therefore be streamed in as one run of low-byte writes, with the upper bits rewritten only when they change.

A ready flag, which the host sets and clears, tells the downstream path that a finished table is waiting. While the flag is set, the template is locked against further commits. The bus that carries register accesses is outside the block and is modelled as a single write strobe with offset and data. Register reads are combinational on a separate read offset. Register accesses have no back-pressure: every strobe is taken in the cycle it is presented. The consumer reads the template through a synchronous index/word port.

Top module: `gamma_lut_loader`

## Requirements
- R1: After reset the index register (offset 0x02), low data register (0x03), high data register (0x04) and ready flag (0x05) all read 0.
- R2: A write to offset 0x02 loads the index register, and the new value reads back at offset 0x02 in the following cycle.
- R3: With the ready flag clear, a write to offset 0x03 stores the word {high bits 1:0, written byte} into the template at the current index.
- R4: Each such commit increments the index by one, and the index wraps from 255 to 0.
- R5: The high data bits keep their value and are reused for every later commit until offset 0x04 is written again.
- R6: While the ready flag is 1, a write to offset 0x03 leaves the template and the index unchanged. The byte is still held in the low data register.
- R7: Readback is zero-filled. Offset 0x03 returns the last byte written there. Offset 0x04 returns the high bits in bits 1:0. Offset 0x05 returns the ready flag in bit 0, and the flag follows bit 0 of a write to 0x05. Every other offset reads 0.
- R8: The template read port returns the word at the applied index one clock edge after the index is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| reg_wr_en | input | 1 | Register write strobe, one cycle per write |
| reg_wr_off | input | 8 | Register write offset |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_off | input | 8 | Register read offset |
| reg_rd_data | output | 8 | Register read data, combinational |
| tbl_idx | input | 8 | Template read index |
| tbl_word | output | 10 | Template word at the index from the previous edge |

## Verification
A wrong index register shows at the ports within one cycle as a wrong readback at offset 0x02. A wrong index also puts committed words in the wrong template slots, which appears one edge after the consumer applies that index on the read port. A stale or clobbered high-bit register only shows once a later commit is read back, so the tests mix commits made before and after rewriting those bits. A lock that leaks lets a locked write overwrite a slot and advance the index, and both effects can be read back in the next cycle.

// File: rtl/lut_ld_pkg.sv
package lut_ld_pkg;
  localparam int REG_W = 8;
  typedef logic [REG_W-1:0] reg_off_t;
  localparam reg_off_t OFF_IDX = 8'h02;
  localparam reg_off_t OFF_LO  = 8'h03;
  localparam reg_off_t OFF_HI  = 8'h04;
  localparam reg_off_t OFF_RDY = 8'h05;
endpackage

// File: rtl/lut_ld_regs.sv
module lut_ld_regs
  import lut_ld_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int HI_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  reg_off_t          wr_off,
  input  logic [REG_W-1:0]  wr_data,
  output logic [ADDR_W-1:0] idx_q,
  output logic [REG_W-1:0]  lo_q,
  output logic [HI_W-1:0]   hi_q,
  output logic              rdy_q,
  output logic              commit
);
  logic hit_idx, hit_lo, hit_hi, hit_rdy;

  always_comb begin
    hit_idx = wr_en && (wr_off == OFF_IDX);
    hit_lo  = wr_en && (wr_off == OFF_LO);
    hit_hi  = wr_en && (wr_off == OFF_HI);
    hit_rdy = wr_en && (wr_off == OFF_RDY);
    commit  = hit_lo && !rdy_q;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      idx_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
      rdy_q <= 1'b0;
    end else begin
      if (hit_idx) idx_q <= wr_data[ADDR_W-1:0];
      else if (commit) idx_q <= idx_q + 1'b1;
      if (hit_lo)  lo_q  <= wr_data;
      if (hit_hi)  hi_q  <= wr_data[HI_W-1:0];
      if (hit_rdy) rdy_q <= wr_data[0];
    end
  end

  // R4
  commit_advance_chk: assert property (@(posedge clk) disable iff (rst)
    commit |=> idx_q == $past(idx_q) + 1'b1);

  // R6
  locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_lo && rdy_q) |=> $stable(idx_q));

  // R2
  idx_load_chk: assert property (@(posedge clk) disable iff (rst)
    hit_idx |=> idx_q == $past(wr_data[ADDR_W-1:0]));

  // R7
  rdy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !hit_rdy |=> $stable(rdy_q));
endmodule

// File: rtl/lut_ld_store.sv
module lut_ld_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] wa,
  input  logic [DATA_W-1:0] wd,
  input  logic [ADDR_W-1:0] ra,
  output logic [DATA_W-1:0] rd
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= mem[ra];
  end
endmodule

// File: rtl/lut_ld_readmux.sv
module lut_ld_readmux
  import lut_ld_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int HI_W   = 2
) (
  input  reg_off_t          rd_off,
  input  logic [ADDR_W-1:0] idx_q,
  input  logic [REG_W-1:0]  lo_q,
  input  logic [HI_W-1:0]   hi_q,
  input  logic              rdy_q,
  output logic [REG_W-1:0]  rd_data
);
  always_comb begin
    rd_data = '0;
    case (rd_off)
      OFF_IDX: rd_data[ADDR_W-1:0] = idx_q;
      OFF_LO:  rd_data             = lo_q;
      OFF_HI:  rd_data[HI_W-1:0]   = hi_q;
      OFF_RDY: rd_data[0]          = rdy_q;
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/gamma_lut_loader.sv
module gamma_lut_loader
  import lut_ld_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr_en,
  input  logic [7:0]        reg_wr_off,
  input  logic [7:0]        reg_wr_data,
  input  logic [7:0]        reg_rd_off,
  output logic [7:0]        reg_rd_data,
  input  logic [ADDR_W-1:0] tbl_idx,
  output logic [DATA_W-1:0] tbl_word
);
  localparam int HI_W = DATA_W - REG_W;

  logic [ADDR_W-1:0] idx_q;
  logic [REG_W-1:0]  lo_q;
  logic [HI_W-1:0]   hi_q;
  logic              rdy_q;
  logic              commit;

  lut_ld_regs #(.ADDR_W(ADDR_W), .HI_W(HI_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .wr_off(reg_wr_off),
    .wr_data(reg_wr_data), .idx_q(idx_q), .lo_q(lo_q), .hi_q(hi_q),
    .rdy_q(rdy_q), .commit(commit)
  );

  lut_ld_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .we(commit), .wa(idx_q), .wd({hi_q, reg_wr_data}),
    .ra(tbl_idx), .rd(tbl_word)
  );

  lut_ld_readmux #(.ADDR_W(ADDR_W), .HI_W(HI_W)) u_rmux (
    .rd_off(reg_rd_off), .idx_q(idx_q), .lo_q(lo_q), .hi_q(hi_q),
    .rdy_q(rdy_q), .rd_data(reg_rd_data)
  );

  // R7
  rdy_zero_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd_off == OFF_RDY) |-> reg_rd_data[7:1] == 7'd0);
endmodule

// File: tb/test_gamma_lut_loader.sv
module test_gamma_lut_loader;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wr_off = '0;
  logic [7:0] reg_wr_data = '0;
  logic [7:0] reg_rd_off = '0;
  logic [7:0] reg_rd_data;
  logic [7:0] tbl_idx = '0;
  logic [9:0] tbl_word;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  gamma_lut_loader i_gamma_lut_loader (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_wr_off(reg_wr_off),
    .reg_wr_data(reg_wr_data), .reg_rd_off(reg_rd_off), .reg_rd_data(reg_rd_data),
    .tbl_idx(tbl_idx), .tbl_word(tbl_word)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] off, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_off = off; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] off, input int exp);
    reg_rd_off = off;
    #1;
    chk(req, int'(reg_rd_data), exp);
  endtask

  task automatic tbl_chk(input string req, input logic [7:0] idx, input int exp);
    @(negedge clk);
    tbl_idx = idx;
    @(negedge clk);
    chk(req, int'(tbl_word), exp);
  endtask

  task automatic t_reset();
    rd_chk("R1 idx", 8'h02, 0);
    rd_chk("R1 lo", 8'h03, 0);
    rd_chk("R1 hi", 8'h04, 0);
    rd_chk("R1 rdy", 8'h05, 0);
  endtask

  task automatic t_idx();
    wr(8'h02, 8'h40);
    rd_chk("R2 idx load", 8'h02, 8'h40);
  endtask

  task automatic t_commit();
    wr(8'h04, 8'h02);
    wr(8'h02, 8'h10);
    wr(8'h03, 8'h33);
    wr(8'h03, 8'h44);
    rd_chk("R4 idx advanced", 8'h02, 8'h12);
    rd_chk("R7 lo readback", 8'h03, 8'h44);
    tbl_chk("R3 word 0x10", 8'h10, 10'h233);
    tbl_chk("R5 hi reused 0x11", 8'h11, 10'h244);
  endtask

  task automatic t_wrap();
    wr(8'h04, 8'hFD);
    rd_chk("R7 hi zero fill", 8'h04, 8'h01);
    wr(8'h02, 8'hFF);
    wr(8'h03, 8'h5A);
    rd_chk("R4 wrap", 8'h02, 8'h00);
    tbl_chk("R3 word 0xFF", 8'hFF, 10'h15A);
  endtask

  task automatic t_lock();
    wr(8'h04, 8'h03);
    wr(8'h05, 8'hFF);
    rd_chk("R7 rdy zero fill", 8'h05, 8'h01);
    wr(8'h02, 8'h10);
    wr(8'h03, 8'h99);
    rd_chk("R6 idx held", 8'h02, 8'h10);
    rd_chk("R6 lo held", 8'h03, 8'h99);
    tbl_chk("R6 template held", 8'h10, 10'h233);
    wr(8'h05, 8'h00);
    rd_chk("R7 rdy clear", 8'h05, 8'h00);
    wr(8'h03, 8'h99);
    rd_chk("R4 unlock advance", 8'h02, 8'h11);
    tbl_chk("R3 unlock commit", 8'h10, 10'h399);
  endtask

  task automatic t_unmapped();
    wr(8'h06, 8'hAA);
    rd_chk("R7 unmapped 0x06", 8'h06, 0);
    rd_chk("R7 unmapped 0x00", 8'h00, 0);
    rd_chk("R7 idx untouched", 8'h02, 8'h11);
  endtask

  task automatic t_latency();
    tbl_chk("R8 first", 8'h11, 10'h244);
    @(negedge clk);
    tbl_idx = 8'hFF;
    #1;
    chk("R8 not before edge", int'(tbl_word), 10'h244);
    @(negedge clk);
    chk("R8 after one edge", int'(tbl_word), 10'h15A);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_idx();
    t_commit();
    t_wrap();
    t_lock();
    t_unmapped();
    t_latency();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule